// File: doc/BRIEF.md
# Fixed-Point Radix-2 Butterfly Unit

This unit carries out one decimation-in-time radix-2 butterfly on signed fixed-point complex samples. It takes a top operand `a`, a bottom operand `b` and a rotation coefficient `tw`. It returns the pair `sum = a + tw·b` and `dif = a − tw·b`. The complex rotation uses four real multiplies. Each full-precision product is brought back to the data scale by a rounding right shift. Both results are then rounded and clamped to the data range, so an overflow never wraps.

An FFT sequencer feeds one operand set per cycle, with `in_valid` marking the live cycles. It picks up the finished pair a fixed number of cycles later, when `out_valid` is high. Coefficient storage, address sequencing and block scaling belong to the sequencer, not to this unit.

Top module: `fxp_butterfly`

## Requirements
- R1: Data words (a, b, sum, dif, real and imaginary) are signed two's complement, 22 bits, with the binary point 4 bits from the right. Coefficients are signed two's complement, 16 bits, with 14 fraction bits, so 16384 means +1.0 and −16384 means −1.0.
- R2: Each of the four real products of b and tw is rounded to data scale as (p + 8192) >>> 14, with an arithmetic shift, so halves round toward +infinity. The real part of tw·b is round(b_re·tw_re) − round(b_im·tw_im). The imaginary part is round(b_im·tw_re) + round(b_re·tw_im).
- R3: sum = a + tw·b and dif = a − tw·b are computed without loss and then clamped per component to the range [−2097152, 2097151].
- R4: A set sampled with `in_valid` high at a rising edge appears on the outputs, with `out_valid` high, right after the third rising edge counted from that sampling edge.
- R5: A synchronous active-high `rst` clears `out_valid` and all four outputs to zero and drops every result still in flight.
- R6: The outputs change only at edges that raise or keep `out_valid` high. Otherwise they hold the last result.
- R7: Operands presented while `in_valid` is low produce no result and do not disturb the held outputs.
- R8: A new operand set can be accepted on every cycle, and results come out in order, one per cycle.
- R9: With tw = 0 the two outputs are equal, both being the top operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand set is live this cycle |
| a_re | input | 22 | Top operand, real part |
| a_im | input | 22 | Top operand, imaginary part |
| b_re | input | 22 | Bottom operand, real part |
| b_im | input | 22 | Bottom operand, imaginary part |
| tw_re | input | 16 | Coefficient, real part |
| tw_im | input | 16 | Coefficient, imaginary part |
| out_valid | output | 1 | Result pair is live |
| sum_re | output | 22 | a + tw·b, real part |
| sum_im | output | 22 | a + tw·b, imaginary part |
| dif_re | output | 22 | a − tw·b, real part |
| dif_im | output | 22 | a − tw·b, imaginary part |

## Verification
Four properties are checked on every cycle: the three-edge valid delay, the cleared state after reset, the outputs holding while `out_valid` is low, and equal outputs whenever a zero coefficient went in. The arithmetic itself can only be shown by the bench's scenarios, which compare results against an integer model. These scenarios cover half-LSB rounding of products, full-scale operands with rotations of +1 and −j that push both outputs into the clamp, random coefficients drawn from a 1024-point table, back-to-back bursts, idle cycles with junk operands, and a reset that lands on results still in flight.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  localparam int unsigned DEF_DATA_W  = 22;  // 18 integer + 4 fraction bits
  localparam int unsigned DEF_TW_W    = 16;
  localparam int unsigned DEF_TW_FRAC = 14;  // 16384 == +1.0
  localparam int unsigned PIPE_LAT    = 3;   // edges from sample to result
endpackage

// File: rtl/bfly_round_shift.sv
// Rounding arithmetic right shift: (din + half LSB) >>> SHIFT.
// The caller guarantees that din plus the bias cannot overflow IN_W bits.
module bfly_round_shift #(
  parameter int unsigned IN_W  = 38,
  parameter int unsigned SHIFT = 14,
  localparam int unsigned OUT_W = IN_W - SHIFT
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  localparam logic [IN_W-1:0] HALF_LSB =
    {{(IN_W-SHIFT){1'b0}}, 1'b1, {(SHIFT-1){1'b0}}};

  logic signed [IN_W-1:0] biased;

  always_comb begin
    biased = din + $signed(HALF_LSB);
    dout   = OUT_W'(biased >>> SHIFT);
  end
endmodule

// File: rtl/bfly_sat.sv
// Clamp a wide signed value into OUT_W bits.
module bfly_sat #(
  parameter int unsigned IN_W  = 26,
  parameter int unsigned OUT_W = 22
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MAX = {1'b1, {(OUT_W-1){1'b0}}};

  logic [IN_W-OUT_W:0] head;
  logic                fits;

  always_comb begin
    head = din[IN_W-1:OUT_W-1];
    fits = (&head) | ~(|head);
    if (fits)             dout = din[OUT_W-1:0];
    else if (din[IN_W-1]) dout = NEG_MAX;
    else                  dout = POS_MAX;
  end
endmodule

// File: rtl/bfly_cmul.sv
// Two-stage complex rotation tw*b: products registered, then rounded and combined.
module bfly_cmul #(
  parameter int unsigned DW = 22,
  parameter int unsigned TW = 16,
  parameter int unsigned TF = 14,
  localparam int unsigned PW  = DW + TW,   // full product width
  localparam int unsigned RW  = PW - TF,   // rounded product width
  localparam int unsigned WGW = RW + 1     // rotated component width
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic signed [DW-1:0]  b_re,
  input  logic signed [DW-1:0]  b_im,
  input  logic signed [TW-1:0]  tw_re,
  input  logic signed [TW-1:0]  tw_im,
  output logic                  wg_valid,
  output logic signed [WGW-1:0] wg_re,
  output logic signed [WGW-1:0] wg_im
);
  localparam int unsigned NPROD = 4;

  // product order: b_re*tw_re, b_im*tw_im, b_im*tw_re, b_re*tw_im
  logic signed [DW-1:0] data_op [NPROD];
  logic signed [TW-1:0] coef_op [NPROD];
  logic signed [PW-1:0] prod_q  [NPROD];
  logic signed [RW-1:0] prod_r  [NPROD];
  logic                 prod_v;

  always_comb begin
    data_op[0] = b_re;  coef_op[0] = tw_re;
    data_op[1] = b_im;  coef_op[1] = tw_im;
    data_op[2] = b_im;  coef_op[2] = tw_re;
    data_op[3] = b_re;  coef_op[3] = tw_im;
  end

  always_ff @(posedge clk) begin
    if (rst) prod_v <= 1'b0;
    else     prod_v <= in_valid;
    if (in_valid) begin
      for (int i = 0; i < NPROD; i++) begin
        prod_q[i] <= data_op[i] * coef_op[i];
      end
    end
  end

  for (genvar gi = 0; gi < NPROD; gi++) begin : g_round
    bfly_round_shift #(.IN_W(PW), .SHIFT(TF)) u_rs (
      .din  (prod_q[gi]),
      .dout (prod_r[gi])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) wg_valid <= 1'b0;
    else     wg_valid <= prod_v;
    if (prod_v) begin
      wg_re <= prod_r[0] - prod_r[1];
      wg_im <= prod_r[2] + prod_r[3];
    end
  end
endmodule

// File: rtl/fxp_butterfly.sv
module fxp_butterfly #(
  parameter int unsigned DATA_W  = bfly_pkg::DEF_DATA_W,
  parameter int unsigned TW_W    = bfly_pkg::DEF_TW_W,
  parameter int unsigned TW_FRAC = bfly_pkg::DEF_TW_FRAC
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] a_re,
  input  logic signed [DATA_W-1:0] a_im,
  input  logic signed [DATA_W-1:0] b_re,
  input  logic signed [DATA_W-1:0] b_im,
  input  logic signed [TW_W-1:0]   tw_re,
  input  logic signed [TW_W-1:0]   tw_im,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] sum_re,
  output logic signed [DATA_W-1:0] sum_im,
  output logic signed [DATA_W-1:0] dif_re,
  output logic signed [DATA_W-1:0] dif_im
);
  localparam int unsigned WGW   = DATA_W + TW_W - TW_FRAC + 1;
  localparam int unsigned SW    = WGW + 1;  // guard bit for the add/subtract
  localparam int unsigned NLANE = 4;        // sum_re, sum_im, dif_re, dif_im

  // top operand delay line, matched to the two rotation stages
  logic signed [DATA_W-1:0] a_re_d1, a_im_d1, a_re_d2, a_im_d2;
  logic                     in_valid_d1;

  always_ff @(posedge clk) begin
    if (rst) in_valid_d1 <= 1'b0;
    else     in_valid_d1 <= in_valid;
    if (in_valid) begin
      a_re_d1 <= a_re;
      a_im_d1 <= a_im;
    end
    if (in_valid_d1) begin
      a_re_d2 <= a_re_d1;
      a_im_d2 <= a_im_d1;
    end
  end

  logic                  wg_valid;
  logic signed [WGW-1:0] wg_re, wg_im;

  bfly_cmul #(.DW(DATA_W), .TW(TW_W), .TF(TW_FRAC)) u_cmul (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .b_re     (b_re),
    .b_im     (b_im),
    .tw_re    (tw_re),
    .tw_im    (tw_im),
    .wg_valid (wg_valid),
    .wg_re    (wg_re),
    .wg_im    (wg_im)
  );

  logic signed [SW-1:0]     lane_wide [NLANE];
  logic signed [DATA_W-1:0] lane_sat  [NLANE];
  logic signed [DATA_W-1:0] lane_q    [NLANE];
  logic                     out_v_q;

  always_comb begin
    lane_wide[0] = a_re_d2 + wg_re;
    lane_wide[1] = a_im_d2 + wg_im;
    lane_wide[2] = a_re_d2 - wg_re;
    lane_wide[3] = a_im_d2 - wg_im;
  end

  for (genvar gl = 0; gl < NLANE; gl++) begin : g_lane
    bfly_sat #(.IN_W(SW), .OUT_W(DATA_W)) u_sat (
      .din  (lane_wide[gl]),
      .dout (lane_sat[gl])
    );

    always_ff @(posedge clk) begin
      if (rst)           lane_q[gl] <= '0;
      else if (wg_valid) lane_q[gl] <= lane_sat[gl];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_v_q <= 1'b0;
    else     out_v_q <= wg_valid;
  end

  assign out_valid = out_v_q;
  assign sum_re    = lane_q[0];
  assign sum_im    = lane_q[1];
  assign dif_re    = lane_q[2];
  assign dif_im    = lane_q[3];
endmodule

// File: rtl/fxp_butterfly_chk.sv
module fxp_butterfly_chk #(
  parameter int unsigned DW = 22,
  parameter int unsigned TW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic signed [TW-1:0] tw_re,
  input logic signed [TW-1:0] tw_im,
  input logic                 out_valid,
  input logic signed [DW-1:0] sum_re,
  input logic signed [DW-1:0] sum_im,
  input logic signed [DW-1:0] dif_re,
  input logic signed [DW-1:0] dif_im
);
  // cycles since reset release, saturating at the pipeline depth
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                                 since_rst <= '0;
    else if (since_rst != 2'(bfly_pkg::PIPE_LAT)) since_rst <= since_rst + 2'd1;
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'(bfly_pkg::PIPE_LAT)) |-> (out_valid == $past(in_valid, 3)));

  assert_reset_clear_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && sum_re == '0 && sum_im == '0 &&
                    dif_re == '0 && dif_im == '0));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !out_valid) |->
      ($stable(sum_re) && $stable(sum_im) && $stable(dif_re) && $stable(dif_im)));

  assert_zero_tw_R9: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'(bfly_pkg::PIPE_LAT) &&
     $past(in_valid && tw_re == '0 && tw_im == '0, 3)) |->
      (sum_re == dif_re && sum_im == dif_im));
endmodule

bind fxp_butterfly fxp_butterfly_chk #(.DW(DATA_W), .TW(TW_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .tw_re     (tw_re),
  .tw_im     (tw_im),
  .out_valid (out_valid),
  .sum_re    (sum_re),
  .sum_im    (sum_im),
  .dif_re    (dif_re),
  .dif_im    (dif_im)
);

// File: tb/fxp_butterfly_tb_top.sv
module fxp_butterfly_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 22;
  localparam int TW = 16;
  localparam int TF = 14;
  localparam longint DMAX = (64'sd1 <<< (DW-1)) - 1;
  localparam longint DMIN = -(64'sd1 <<< (DW-1));
  localparam longint ONE  = 64'sd1 <<< TF;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
  logic signed [TW-1:0] tw_re = '0, tw_im = '0;
  logic out_valid;
  logic signed [DW-1:0] sum_re, sum_im, dif_re, dif_im;

  always #(CLK_PERIOD/2) clk = ~clk;

  fxp_butterfly dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .tw_re(tw_re), .tw_im(tw_im),
    .out_valid(out_valid),
    .sum_re(sum_re), .sum_im(sum_im), .dif_re(dif_re), .dif_im(dif_im)
  );

  typedef struct {
    longint sre, sim, dre, dim;
    longint due;
    string  tag;
  } exp_t;

  exp_t   sb_q[$];
  longint cyc = 0;
  int     n_checks = 0;
  int     n_errors = 0;
  bit     finished = 1'b0;
  longint last_sre = 0, last_sim = 0, last_dre = 0, last_dim = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // integer model of the requirements
  function automatic longint rnd_p(input longint p);
    return (p + (ONE >>> 1)) >>> TF;   // R2: half LSB, then arithmetic shift
  endfunction

  function automatic longint clamp(input longint v);
    if (v > DMAX) return DMAX;
    if (v < DMIN) return DMIN;
    return v;
  endfunction

  task automatic send(input longint ar, input longint ai, input longint br,
                      input longint bi, input longint wr, input longint wi,
                      input string tag);
    exp_t e;
    longint xr, xi;
    @(negedge clk);
    a_re = DW'(ar); a_im = DW'(ai); b_re = DW'(br); b_im = DW'(bi);
    tw_re = TW'(wr); tw_im = TW'(wi);
    in_valid = 1'b1;
    xr = rnd_p(br * wr) - rnd_p(bi * wi);
    xi = rnd_p(bi * wr) + rnd_p(br * wi);
    e.sre = clamp(ar + xr); e.sim = clamp(ai + xi);
    e.dre = clamp(ar - xr); e.dim = clamp(ai - xi);
    e.due = cyc + 3;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      a_re = DW'($urandom); a_im = DW'($urandom);
      b_re = DW'($urandom); b_im = DW'($urandom);
      tw_re = TW'($urandom); tw_im = TW'($urandom);
    end
  endtask

  function automatic longint rnd_data();
    return longint'($urandom_range(0, 32'h3FFFFF)) + DMIN;
  endfunction

  task automatic send_random(input string tag);
    int k;
    real ang;
    longint wr, wi;
    k   = int'($urandom_range(0, 511));
    ang = 2.0 * 3.14159265358979 * real'(k) / 1024.0;
    wr  = longint'($floor(real'(ONE) * $cos(ang) + 0.5));
    wi  = longint'($floor(-real'(ONE) * $sin(ang) + 0.5));
    send(rnd_data(), rnd_data(), rnd_data(), rnd_data(), wr, wi, tag);
  endtask

  // monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb_q.size() == 0) begin
        check("R7", "unexpected out_valid", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, "sum_re", longint'(sum_re), e.sre);
        check(e.tag, "sum_im", longint'(sum_im), e.sim);
        check(e.tag, "dif_re", longint'(dif_re), e.dre);
        check(e.tag, "dif_im", longint'(dif_im), e.dim);
        check("R4", "result cycle", cyc, e.due);
        last_sre = e.sre; last_sim = e.sim; last_dre = e.dre; last_dim = e.dim;
      end
    end
  end

  task automatic check_hold(input string req);
    check(req, "out_valid while idle", longint'(out_valid), 0);
    check(req, "held sum_re", longint'(sum_re), last_sre);
    check(req, "held sum_im", longint'(sum_im), last_sim);
    check(req, "held dif_re", longint'(dif_re), last_dre);
    check(req, "held dif_im", longint'(dif_im), last_dim);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R5: reset state
    check("R5", "out_valid in reset", longint'(out_valid), 0);
    check("R5", "sum_re in reset", longint'(sum_re), 0);
    check("R5", "dif_im in reset", longint'(dif_im), 0);
    rst = 1'b0;

    // R1: fractional format, 1.5 + 0.5*0.25
    send(24, -8, 4, 0, ONE / 2, 0, "R1");
    // R2: rounding of products at exactly half an LSB
    send(0, 0, 1, 0, ONE / 2, 0, "R2");
    send(0, 0, -1, 0, ONE / 2, 0, "R2");
    send(0, 0, 3, -5, ONE / 2, -(ONE / 2), "R2");
    send(100, 50, 7, 9, 11585, -11585, "R2");
    idle(6);
    // R6/R7: junk operands while idle leave the last result on the outputs
    check_hold("R6");
    idle(3);
    check_hold("R7");

    // R3: full-scale saturation corners with tw = +1 and tw = -j
    send(DMAX, DMAX, DMAX, DMAX, ONE, 0, "R3");
    send(DMIN, DMIN, DMIN, DMIN, ONE, 0, "R3");
    send(DMAX, DMIN, DMIN, DMAX, ONE, 0, "R3");
    send(DMAX, DMAX, DMIN, DMIN, 0, -ONE, "R3");
    send(DMIN, DMAX, DMAX, DMIN, 0, -ONE, "R3");
    send(DMIN, DMIN, DMIN, DMAX, -ONE, 0, "R3");
    // R9: zero coefficient
    send(12345, -54321, DMAX, DMIN, 0, 0, "R9");
    send(DMIN, DMAX, 777, -3, 0, 0, "R9");
    idle(5);

    // R8: back-to-back random burst
    for (int i = 0; i < 200; i++) send_random("R8");
    idle(5);
    // sparse random traffic
    for (int i = 0; i < 100; i++) begin
      send_random("R3");
      if (i % 3 == 0) idle(1 + i % 4);
    end
    idle(6);

    // R5: reset while results are in flight drops them
    send(1000, 1000, 1000, 1000, ONE, 0, "R5");
    send(2000, 2000, 2000, 2000, ONE, 0, "R5");
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    sb_q.delete();
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R5", "out_valid after reset", longint'(out_valid), 0);
    check("R5", "sum_re after reset", longint'(sum_re), 0);
    last_sre = 0; last_sim = 0; last_dre = 0; last_dim = 0;
    idle(5);
    check_hold("R5");

    send(-7, 3, 40, -40, ONE, ONE, "R3");
    idle(6);
    check("R8", "scoreboard drained", longint'(sb_q.size()), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule